// File: doc/BRIEF.md
# Single-Wire RGB LED Stream Encoder

This block turns a stream of 24-bit colour words into the serial waveform that a chain of addressable RGB LEDs expects on one data line. Words arrive through a valid/ready handshake. Each word carries an end-of-frame marker. A single holding register sits between the handshake and the serializer, so the next word can wait while the current one is being sent.

Every colour bit is sent as a symbol of three equal time slots, and the high part of the symbol always comes first. A zero is high for one slot and low for two. A one is high for two slots and low for one. The LED samples the line in the middle of the symbol, so the middle slot carries the bit value. The slot length comes from a clock divider, which by default gives about 2.4 MHz from 125 MHz.

After the word marked as end of frame, the line is held low for a programmable number of slots. This makes the chain latch its data and start again from the first LED. If the next word of a frame does not arrive in time, the line stays low and an underrun flag is raised until data resumes.

Top module: `led_stream_encoder`

## Requirements
- R1: After reset the line is low, `pix_ready` is 1 and `underrun` is 0.
- R2: Each word is split as red = `pix_rgb[23:16]`, green = `pix_rgb[15:8]`, blue = `pix_rgb[7:0]`. The bytes go onto the line in the order green, red, blue.
- R3: Within each byte, bits are sent most-significant first.
- R4: Each bit is a 3-slot symbol that starts high. A 0 is high for 1 slot and then low for 2 slots. A 1 is high for 2 slots and then low for 1 slot.
- R5: One slot lasts `CLK_DIV` clock cycles. The 24 symbols of a word follow each other with no gap, so symbol starts are exactly 3·`CLK_DIV` cycles apart.
- R6: Within a frame, if the next word is already held when a word finishes, its first symbol starts exactly 3·`CLK_DIV` cycles after the start of the previous word's last symbol.
- R7: After a word marked `pix_last`, the line stays low for at least `RESET_SLOTS` slots before the next frame's first symbol starts. The rise-to-rise gap is at least (3 + `RESET_SLOTS`)·`CLK_DIV` cycles.
- R8: If a non-last word finishes and no word is held, the line stays low and `underrun` is 1. Both last until a word arrives, and then sending resumes with that word.
- R9: `pix_ready` is 1 only while the holding register is empty. While it is 0, a word presented on `pix_valid` is not captured and never appears on the line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Colour word offered |
| pix_ready | output | 1 | Holding register empty; word will be taken |
| pix_rgb | input | 24 | Colour word, red in the top byte |
| pix_last | input | 1 | Word is the last of its frame |
| led_line | output | 1 | Serial data line to the LED chain |
| underrun | output | 1 | Line idling inside a frame for lack of data |

## Verification
The assertions check the following on every cycle:
- the symbol shape: the first slot is high and the final slot is low;
- the line is low throughout the reset interval and whenever `underrun` is set;
- slot ticks are isolated pulses;
- a queued word stays unchanged until the serializer takes it.

Other behaviours only show up in the bench's scenarios:
- the green-red-blue byte order and the bit order, which the bench recovers by decoding the line;
- exact symbol and word spacing;
- the length of the reset gap;
- resumption after an underrun;
- that a word offered while the register is full is dropped.

// File: rtl/ledenc_pkg.sv
package ledenc_pkg;

  localparam int unsigned WORD_W = 24;
  localparam int unsigned SLOTS_PER_BIT = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEND  = 2'd1,
    ST_STALL = 2'd2,
    ST_LATCH = 2'd3
  } enc_state_t;

  // Reorder an R,G,B word into the on-wire sequence G,R,B.
  function automatic logic [WORD_W-1:0] wire_order(input logic [WORD_W-1:0] rgb);
    return {rgb[15:8], rgb[23:16], rgb[7:0]};
  endfunction

  // Line level during a given slot of a symbol carrying bit b.
  function automatic logic slot_level(input logic b, input logic [1:0] slot);
    logic lvl;
    case (slot)
      2'd0:    lvl = 1'b1;
      2'd1:    lvl = b;
      default: lvl = 1'b0;
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/ledenc_slot_timer.sv
module ledenc_slot_timer #(
  parameter int unsigned CLK_DIV = 52
) (
  input  logic clk,
  input  logic rst_n,
  output logic slot_tick
);
  localparam int unsigned CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(CLK_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (cnt_q == CNT_MAX) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  assign slot_tick = (cnt_q == CNT_MAX);

  generate
    if (CLK_DIV > 1) begin : g_tick_chk
      assert_tick_isolated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        slot_tick |=> !slot_tick);
    end
  endgenerate
endmodule

// File: rtl/ledenc_hold_reg.sv
module ledenc_hold_reg
  import ledenc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_rgb,
  input  logic              in_last,
  input  logic              take,
  output logic              held,
  output logic [WORD_W-1:0] held_rgb,
  output logic              held_last
);
  logic accept;

  assign in_ready = !held;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held      <= 1'b0;
      held_rgb  <= '0;
      held_last <= 1'b0;
    end else if (take) begin
      held <= 1'b0;
    end else if (accept) begin
      held      <= 1'b1;
      held_rgb  <= in_rgb;
      held_last <= in_last;
    end
  end

  assert_hold_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !take) |=> (held && $stable(held_rgb) && $stable(held_last)));
  assert_take_only_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> held);
endmodule

// File: rtl/ledenc_symbol_fsm.sv
module ledenc_symbol_fsm
  import ledenc_pkg::*;
#(
  parameter int unsigned RESET_SLOTS = 120
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_tick,
  input  logic              held,
  input  logic [WORD_W-1:0] held_rgb,
  input  logic              held_last,
  output logic              take,
  output logic              line,
  output logic              underrun
);
  localparam int unsigned BIT_W = $clog2(WORD_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);
  localparam int unsigned RC_W = (RESET_SLOTS > 1) ? $clog2(RESET_SLOTS) : 1;
  localparam logic [RC_W-1:0] RC_MAX = RC_W'(RESET_SLOTS - 1);

  enc_state_t        st_q;
  logic [WORD_W-1:0] sh_q;
  logic [BIT_W-1:0]  bit_q;
  logic [1:0]        slot_q;
  logic [RC_W-1:0]   rc_q;
  logic              last_q;

  // Named events for the assertions.
  logic sym_end, word_end, load_evt, stall_evt;

  assign sym_end   = slot_tick && (st_q == ST_SEND) && (slot_q == 2'd2);
  assign word_end  = sym_end && (bit_q == LAST_BIT);
  assign load_evt  = slot_tick && held &&
                     ((st_q == ST_IDLE) || (st_q == ST_STALL) || (word_end && !last_q));
  assign stall_evt = word_end && !last_q && !held;
  assign take      = load_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sh_q   <= '0;
      bit_q  <= '0;
      slot_q <= '0;
      rc_q   <= '0;
      last_q <= 1'b0;
      line   <= 1'b0;
    end else if (load_evt) begin
      st_q   <= ST_SEND;
      sh_q   <= wire_order(held_rgb);
      last_q <= held_last;
      bit_q  <= '0;
      slot_q <= '0;
      line   <= 1'b1;
    end else if (slot_tick) begin
      case (st_q)
        ST_SEND: begin
          if (slot_q == 2'd2) begin
            if (bit_q == LAST_BIT) begin
              line <= 1'b0;
              if (last_q) begin
                st_q <= ST_LATCH;
                rc_q <= '0;
              end else begin
                st_q <= ST_STALL;
              end
            end else begin
              sh_q   <= {sh_q[WORD_W-2:0], 1'b0};
              bit_q  <= bit_q + 1'b1;
              slot_q <= '0;
              line   <= 1'b1;
            end
          end else begin
            slot_q <= slot_q + 2'd1;
            line   <= slot_level(sh_q[WORD_W-1], 2'(slot_q + 2'd1));
          end
        end
        ST_LATCH: begin
          line <= 1'b0;
          if (rc_q == RC_MAX) st_q <= ST_IDLE;
          else                rc_q <= rc_q + 1'b1;
        end
        default: line <= 1'b0;
      endcase
    end
  end

  assign underrun = (st_q == ST_STALL);

  assert_sym_head_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> line);
  assert_sym_tail_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SEND && slot_q == 2'd2) |-> !line);
  assert_slot_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q != 2'd3);
  assert_latch_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LATCH) |-> !line);
  assert_stall_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> !line);
  assert_stall_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stall_evt |=> underrun);
endmodule

// File: rtl/led_stream_encoder.sv
module led_stream_encoder
  import ledenc_pkg::*;
#(
  parameter int unsigned CLK_DIV     = 52,
  parameter int unsigned RESET_SLOTS = 120
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pix_valid,
  output logic        pix_ready,
  input  logic [23:0] pix_rgb,
  input  logic        pix_last,
  output logic        led_line,
  output logic        underrun
);
  logic              slot_tick;
  logic              take;
  logic              held;
  logic [WORD_W-1:0] held_rgb;
  logic              held_last;

  ledenc_slot_timer #(.CLK_DIV(CLK_DIV)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_tick (slot_tick)
  );

  ledenc_hold_reg u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (pix_valid),
    .in_ready  (pix_ready),
    .in_rgb    (pix_rgb),
    .in_last   (pix_last),
    .take      (take),
    .held      (held),
    .held_rgb  (held_rgb),
    .held_last (held_last)
  );

  ledenc_symbol_fsm #(.RESET_SLOTS(RESET_SLOTS)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_tick (slot_tick),
    .held      (held),
    .held_rgb  (held_rgb),
    .held_last (held_last),
    .take      (take),
    .line      (led_line),
    .underrun  (underrun)
  );

  assert_ready_tracks_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_ready) |=> !pix_ready);
endmodule

// File: tb/led_stream_encoder_tb.sv
module led_stream_encoder_tb;
  localparam int DIV = 4;
  localparam int RST_SLOTS = 10;
  localparam int SYM = 3 * DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_valid = 1'b0;
  logic pix_ready;
  logic [23:0] pix_rgb = '0;
  logic pix_last = 1'b0;
  logic led_line;
  logic underrun;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  led_stream_encoder #(.CLK_DIV(DIV), .RESET_SLOTS(RST_SLOTS)) u_dut (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_rgb(pix_rgb), .pix_last(pix_last), .led_line(led_line), .underrun(underrun)
  );

  // {last, rgb}
  localparam logic [24:0] VEC [8] = '{
    {1'b0, 24'hFF0000}, {1'b0, 24'h00FF00}, {1'b1, 24'h0000FF},
    {1'b0, 24'h8001A5}, {1'b1, 24'h5A3C96},
    {1'b0, 24'h000000}, {1'b0, 24'hFFFFFF}, {1'b1, 24'h123456}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] on_wire(input logic [23:0] rgb);
    logic [7:0] r, g, b;
    r = rgb[23:16]; g = rgb[15:8]; b = rgb[7:0];
    return {g, r, b};
  endfunction

  task automatic push(input logic [23:0] rgb, input logic last);
    @(negedge clk);
    while (!pix_ready) @(negedge clk);
    pix_rgb = rgb; pix_last = last; pix_valid = 1'b1;
    @(negedge clk);
    pix_valid = 1'b0;
  endtask

  // Decode one 24-bit word from the line; report first/last symbol rise cycles.
  task automatic get_word(output logic [23:0] w, output int first_rise, output int last_rise,
                          output bit shape_ok, output bit spacing_ok, output bit flag_seen);
    int prev;
    logic s0, s1, s2;
    shape_ok = 1; spacing_ok = 1; flag_seen = 0; w = '0;
    first_rise = 0; last_rise = 0; prev = 0;
    for (int b = 0; b < 24; b++) begin
      int to;
      to = 0;
      @(negedge clk);
      while (!led_line && to < 5000) begin @(negedge clk); to++; end
      if (b == 0) first_rise = cyc;
      else if (cyc - prev != SYM) spacing_ok = 0;
      prev = cyc;
      repeat (1) @(negedge clk); s0 = led_line; flag_seen |= underrun;
      repeat (DIV) @(negedge clk); s1 = led_line;
      repeat (DIV) @(negedge clk); s2 = led_line;
      if (!s0 || s2) shape_ok = 0;
      w = {w[22:0], s1};
    end
    last_rise = prev;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [23:0] w;
    int fr, lr, prev_lr;
    bit sh, sp, fl, hi_seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(led_line == 1'b0, "R1 line low", led_line, 0);
    check(pix_ready == 1'b1, "R1 ready", pix_ready, 1);
    check(underrun == 1'b0, "R1 underrun", underrun, 0);

    // Table walk: R2 R3 R4 R5 R6 R7
    prev_lr = 0;
    fork
      begin
        for (int i = 0; i < 8; i++) push(VEC[i][23:0], VEC[i][24]);
      end
      begin
        for (int i = 0; i < 8; i++) begin
          get_word(w, fr, lr, sh, sp, fl);
          check(w == on_wire(VEC[i][23:0]), "R2/R3 GRB MSB-first word", w, on_wire(VEC[i][23:0]));
          check(sh, "R4 symbol shape", sh, 1);
          check(sp, "R5 symbol spacing", sp, 1);
          check(!fl, "R8 no underrun when fed", fl, 0);
          if (i > 0 && VEC[i-1][24])
            check(fr - prev_lr >= (3 + RST_SLOTS) * DIV, "R7 latch gap", fr - prev_lr, (3 + RST_SLOTS) * DIV);
          else if (i > 0)
            check(fr - prev_lr == SYM, "R6 word back-to-back", fr - prev_lr, SYM);
          prev_lr = lr;
        end
      end
    join

    // Underrun: R8
    repeat (200) @(negedge clk);
    fork
      push(24'hA5C30F, 1'b0);
      get_word(w, fr, lr, sh, sp, fl);
    join
    check(w == on_wire(24'hA5C30F), "R8 word before stall", w, on_wire(24'hA5C30F));
    repeat (SYM + 4) @(negedge clk);
    check(underrun == 1'b1, "R8 underrun raised", underrun, 1);
    hi_seen = 0;
    for (int k = 0; k < 40; k++) begin @(negedge clk); hi_seen |= led_line; end
    check(!hi_seen, "R8 line low in stall", hi_seen, 0);
    fork
      push(24'h0F1E2D, 1'b1);
      get_word(w, fr, lr, sh, sp, fl);
    join
    check(w == on_wire(24'h0F1E2D), "R8 resume word", w, on_wire(24'h0F1E2D));
    check(underrun == 1'b0, "R8 underrun cleared", underrun, 0);

    // Ignored word while full: R9
    repeat (RST_SLOTS * DIV + 40) @(negedge clk);
    fork
      begin
        push(24'h112233, 1'b0);
        push(24'h445566, 1'b1);
        @(negedge clk);
        check(pix_ready == 1'b0, "R9 ready low when full", pix_ready, 0);
        pix_rgb = 24'hDEAD77; pix_last = 1'b1; pix_valid = 1'b1;
        for (int k = 0; k < 20; k++) @(negedge clk);
        pix_valid = 1'b0;
      end
      begin
        get_word(w, fr, lr, sh, sp, fl);
        check(w == on_wire(24'h112233), "R9 first word", w, on_wire(24'h112233));
        get_word(w, fr, lr, sh, sp, fl);
        check(w == on_wire(24'h445566), "R9 queued word intact", w, on_wire(24'h445566));
      end
    join
    hi_seen = 0;
    for (int k = 0; k < (RST_SLOTS + 10) * DIV; k++) begin @(negedge clk); hi_seen |= led_line; end
    check(!hi_seen, "R9 refused word not sent", hi_seen, 0);
    check(pix_ready == 1'b1, "R9 ready after drain", pix_ready, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule